// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel with PWM

This block is one timer/counter channel driven through a small set of host write strobes. Each count step comes from one of two sources: every clock cycle, or an external event pin. The event pin is synchronised and edge-detected, so each event gives exactly one step. A run level and an optional gate input decide whether steps are taken at all.

The channel has three active modes:
- **Variable width:** the counter wraps at a programmable width between 9 and 16 bits.
- **Reload:** a full 16-bit counter restarts from a reload register each time it overflows.
- **PWM:** an 8-bit modulator advances once per prescaler period. The prescaler divisor and the compare value both come from the reload register.

Every wrap sets a sticky flag, which the host clears by pulsing a clear strobe. The host may also load the counter directly at any time.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count, prescaler and flag are zero and `pwm_o` is low. The control register selects the variable-width mode with width code 4 (13 bits), gating off, clock source.
- R2: The control word is `{ext_src[6], gate_en[5], wcode[4:2], mode[1:0]}`. Mode codes are: 0 variable width, 1 reload, 2 PWM, 3 hold. In mode 0 the width is 9+wcode bits. A step from the all-ones value of that width gives 0 and sets the flag; other steps add 1 within the width.
- R3: In mode 1 a step from 16'hFFFF loads the reload register and sets the flag. Other steps add 1.
- R4: In mode 2 the prescaler divides steps by reload[15:8]+1. Each prescaler period advances the 8-bit counter in `cnt_o[7:0]` with `cnt_o[15:8]` reading zero. A wrap from 255 to 0 sets the flag.
- R5: `pwm_o` is high only in mode 2 while `cnt_o[7:0]` is below reload[7:0]. A compare of 0 keeps it low, and a compare of 255 gives 255 high states out of 256.
- R6: A step is taken only when `run_en` is high and either `gate_en` is clear or `gate_i` is high. Otherwise the count holds.
- R7: With `ext_src` set, one step is taken per high-to-low transition of `evt_i`, detected after two synchronising stages. A steady `evt_i` gives no steps.
- R8: The flag stays set until `ovf_clr` is pulsed. If a wrap and a clear occur in the same cycle, the flag ends set.
- R9: `cnt_we` loads `cnt_wdata` and zeroes the prescaler. It takes priority over a step in the same cycle.
- R10: In mode 3 the count holds and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 7 | Control word (see R2) |
| rld_we | input | 1 | Write strobe for the reload register |
| rld_wdata | input | 16 | Reload value; in PWM mode {divisor, compare} |
| cnt_we | input | 1 | Write strobe for the counter |
| cnt_wdata | input | 16 | Counter load value |
| ovf_clr | input | 1 | Clears the overflow flag |
| run_en | input | 1 | Run level |
| gate_i | input | 1 | Gate input, used when gating is enabled |
| evt_i | input | 1 | External event pin |
| cnt_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit prescaler, an 8-bit modulator and a base width of 9. These defaults reach both ends of the width field (9 and 16 bits) and the full 256-state PWM period within a few hundred cycles. A prescaler divisor of 2 shows the division, and divisor 0 gives a modulator step on every tick. Direct counter loads bring each wrap point within one or two steps, so every overflow boundary is reached in a few cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_VAR  = 2'd0,
    MODE_RLD  = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_HOLD = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic       ext_src;
    logic       gate_en;
    logic [2:0] wcode;
    tmr_mode_e  mode;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);
endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  output logic fall_o
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], evt_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];
endmodule

// File: rtl/tmr_cnt_next.sv
module tmr_cnt_next
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int PWM_W  = 8,
  parameter int WC_W   = 3,
  parameter int W_BASE = 9
) (
  input  tmr_mode_e        mode,
  input  logic [WC_W-1:0]  wcode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [PRE_W-1:0] pre,
  input  logic [CNT_W-1:0] rld,
  output logic [CNT_W-1:0] cnt_nx,
  output logic [PRE_W-1:0] pre_nx,
  output logic             wrap
);
  localparam int DIV_HI = PRE_W + PWM_W - 1;

  logic [CNT_W-1:0] mask;
  logic [PWM_W-1:0] pwm_inc;
  logic [PRE_W-1:0] div;

  assign div     = rld[DIV_HI -: PRE_W];
  assign pwm_inc = cnt[PWM_W-1:0] + PWM_W'(1);

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < W_BASE + int'(wcode));
  end

  always_comb begin
    cnt_nx = cnt;
    pre_nx = '0;
    wrap   = 1'b0;
    case (mode)
      MODE_VAR: begin
        if ((cnt & mask) == mask) begin
          cnt_nx = '0;
          wrap   = 1'b1;
        end else begin
          cnt_nx = (cnt + CNT_W'(1)) & mask;
        end
      end
      MODE_RLD: begin
        if (&cnt) begin
          cnt_nx = rld;
          wrap   = 1'b1;
        end else begin
          cnt_nx = cnt + CNT_W'(1);
        end
      end
      MODE_PWM: begin
        if (pre == div) begin
          pre_nx = '0;
          cnt_nx = {{(CNT_W-PWM_W){1'b0}}, pwm_inc};
          wrap   = &cnt[PWM_W-1:0];
        end else begin
          pre_nx = pre + PRE_W'(1);
        end
      end
      default: begin
        cnt_nx = cnt;
      end
    endcase
  end
endmodule

// File: rtl/tmr_pwm_out.sv
module tmr_pwm_out
  import tmr_pkg::*;
#(
  parameter int PWM_W = 8
) (
  input  tmr_mode_e        mode,
  input  logic [PWM_W-1:0] cnt,
  input  logic [PWM_W-1:0] cmp,
  output logic             pwm_o
);
  assign pwm_o = (mode == MODE_PWM) && (cnt < cmp);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int PWM_W  = 8,
  parameter int W_BASE = 9,
  parameter int RST_WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [6:0]       ctl_wdata,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] rld_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ovf_clr,
  input  logic             run_en,
  input  logic             gate_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             pwm_o
);
  localparam int WC_W = 3;
  localparam logic [WC_W-1:0] RST_WC = WC_W'(RST_WIDTH - W_BASE);

  tmr_ctl_t         ctl_q, ctl_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nx;
  logic [PRE_W-1:0] pre_q, pre_d, pre_nx;
  logic             ovf_q, ovf_d;
  logic             evt_fall, tick, wrap;

  tmr_evt_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .fall_o (evt_fall)
  );

  tmr_cnt_next #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .PWM_W(PWM_W),
    .WC_W(WC_W), .W_BASE(W_BASE)
  ) u_next (
    .mode   (ctl_q.mode),
    .wcode  (ctl_q.wcode),
    .cnt    (cnt_q),
    .pre    (pre_q),
    .rld    (rld_q),
    .cnt_nx (cnt_nx),
    .pre_nx (pre_nx),
    .wrap   (wrap)
  );

  tmr_pwm_out #(.PWM_W(PWM_W)) u_pwm (
    .mode  (ctl_q.mode),
    .cnt   (cnt_q[PWM_W-1:0]),
    .cmp   (rld_q[PWM_W-1:0]),
    .pwm_o (pwm_o)
  );

  assign tick = run_en
              & (~ctl_q.gate_en | gate_i)
              & (~ctl_q.ext_src | evt_fall);

  always_comb begin
    ctl_d = ctl_we ? tmr_ctl_t'(ctl_wdata) : ctl_q;
    rld_d = rld_we ? rld_wdata : rld_q;
    cnt_d = cnt_q;
    pre_d = pre_q;
    if (cnt_we) begin
      cnt_d = cnt_wdata;
      pre_d = '0;
    end else if (tick) begin
      cnt_d = cnt_nx;
      pre_d = pre_nx;
    end
    ovf_d = (tick & ~cnt_we & wrap) | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{ext_src: 1'b0, gate_en: 1'b0, wcode: RST_WC, mode: MODE_VAR};
      rld_q <= '0;
      cnt_q <= '0;
      pre_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      rld_q <= rld_d;
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16,
  parameter int PWM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             gate_i,
  input logic             gate_en,
  input logic             cnt_we,
  input logic             ovf_clr,
  input logic [1:0]       mode,
  input logic [PWM_W-1:0] cmp,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ovf_o,
  input logic             pwm_o
);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_we) |=> $stable(cnt_o));

  a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && gate_en && !gate_i && !cnt_we) |=> $stable(cnt_o));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr) |=> ovf_o);

  a_r5_cmp_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && cmp == '0) |-> !pwm_o);

  a_r5_other_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |-> !pwm_o);

  a_r10_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !cnt_we) |=> $stable(cnt_o));

  a_r3_reload_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_o) && $past(mode) == 2'd1) |-> $past(cnt_o) == '1);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W), .PWM_W(PWM_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_en  (run_en),
  .gate_i  (gate_i),
  .gate_en (ctl_q.gate_en),
  .cnt_we  (cnt_we),
  .ovf_clr (ovf_clr),
  .mode    (ctl_q.mode),
  .cmp     (rld_q[PWM_W-1:0]),
  .cnt_o   (cnt_o),
  .ovf_o   (ovf_o),
  .pwm_o   (pwm_o)
);

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [6:0]  ctl_wdata = '0;
  logic        rld_we = 1'b0;
  logic [15:0] rld_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        ovf_clr = 1'b0;
  logic        run_en = 1'b0;
  logic        gate_i = 1'b0;
  logic        evt_i = 1'b1;
  logic [15:0] cnt_o;
  logic        ovf_o;
  logic        pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_chan u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .ovf_clr(ovf_clr), .run_en(run_en),
    .gate_i(gate_i), .evt_i(evt_i),
    .cnt_o(cnt_o), .ovf_o(ovf_o), .pwm_o(pwm_o)
  );

  typedef struct packed {
    logic [6:0]  ctl;
    logic [15:0] rld;
    logic [15:0] pre;
    logic [15:0] n;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{7'h00, 16'h0000, 16'h01FE, 16'd1,  16'h01FF, 1'b0}, // R2 9-bit below top
    '{7'h00, 16'h0000, 16'h01FF, 16'd1,  16'h0000, 1'b1}, // R2 9-bit wrap
    '{7'h1C, 16'h0000, 16'hFFFE, 16'd3,  16'h0001, 1'b1}, // R2 16-bit wrap
    '{7'h10, 16'h0000, 16'h1FFD, 16'd5,  16'h0002, 1'b1}, // R2 13-bit wrap
    '{7'h0C, 16'h0000, 16'h0100, 16'd10, 16'h010A, 1'b0}, // R2 12-bit plain
    '{7'h01, 16'h1234, 16'hFFFF, 16'd1,  16'h1234, 1'b1}, // R3 reload
    '{7'h01, 16'hFF00, 16'hFFFE, 16'd4,  16'hFF02, 1'b1}, // R3 reload then count
    '{7'h02, 16'h0280, 16'h0000, 16'd9,  16'h0003, 1'b0}, // R4 divide by 3
    '{7'h02, 16'h0040, 16'h00FE, 16'd3,  16'h0001, 1'b1}, // R4 8-bit wrap
    '{7'h03, 16'h0000, 16'h0055, 16'd5,  16'h0055, 1'b0}  // R10 hold mode
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [6:0] ctl, input logic [15:0] rld, input logic [15:0] pre);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = ctl;
    rld_we = 1'b1; rld_wdata = rld;
    cnt_we = 1'b1; cnt_wdata = pre;
    ovf_clr = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; rld_we = 1'b0; cnt_we = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic run_for(input int n);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
    run_en = 1'b0;
  endtask

  task automatic duty(input logic [7:0] cmp, input int exp_hi, input string tag);
    int hi;
    hi = 0;
    setup(7'h02, {8'h00, cmp}, 16'h0000);
    run_en = 1'b1;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (pwm_o) hi++;
    end
    run_en = 1'b0;
    check(tag, hi, exp_hi);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", cnt_o, 0);
    check("R1 flag", ovf_o, 0);
    check("R1 pwm", pwm_o, 0);
    // R1 default width is 13 bits: load without touching control
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = 16'h1FFF;
    @(negedge clk); cnt_we = 1'b0;
    run_for(1);
    check("R1 default 13-bit wrap count", cnt_o, 0);
    check("R1 default 13-bit wrap flag", ovf_o, 1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].ctl, VECS[v].rld, VECS[v].pre);
      run_for(int'(VECS[v].n));
      check($sformatf("vector %0d count", v), cnt_o, VECS[v].exp_cnt);
      check($sformatf("vector %0d flag", v), ovf_o, VECS[v].exp_ovf);
    end

    // R8 sticky flag and clear
    setup(7'h00, 16'h0000, 16'h01FF);
    run_for(4);
    check("R8 flag sticky", ovf_o, 1);
    check("R8 count after wrap", cnt_o, 3);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R8 flag cleared", ovf_o, 0);
    // R8 set wins over clear
    setup(7'h00, 16'h0000, 16'h01FF);
    run_en = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); run_en = 1'b0; ovf_clr = 1'b0;
    check("R8 set beats clear", ovf_o, 1);

    // R9 load beats step
    setup(7'h10, 16'h0000, 16'h0000);
    run_en = 1'b1; cnt_we = 1'b1; cnt_wdata = 16'h0ABC;
    @(negedge clk); run_en = 1'b0; cnt_we = 1'b0;
    check("R9 load priority", cnt_o, 16'h0ABC);
    // R9 load clears prescaler: divide by 3, two ticks, reload, two ticks -> no step
    setup(7'h02, 16'h0200, 16'h0000);
    run_for(2);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = 16'h0010;
    @(negedge clk); cnt_we = 1'b0;
    run_for(2);
    check("R9 prescaler restarted", cnt_o, 16'h0010);

    // R6 gating
    setup(7'h30, 16'h0000, 16'h0007);
    gate_i = 1'b0;
    run_for(5);
    check("R6 gate low holds", cnt_o, 7);
    gate_i = 1'b1;
    run_for(5);
    check("R6 gate high counts", cnt_o, 12);
    gate_i = 1'b0;
    setup(7'h10, 16'h0000, 16'h0020);
    repeat (5) @(negedge clk);
    check("R6 run low holds", cnt_o, 16'h0020);

    // R7 external events
    evt_i = 1'b1;
    setup(7'h50, 16'h0000, 16'h0000);
    run_en = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 steady input no step", cnt_o, 0);
    for (int k = 0; k < 4; k++) begin
      evt_i = 1'b0;
      repeat (3) @(negedge clk);
      evt_i = 1'b1;
      repeat (3) @(negedge clk);
    end
    evt_i = 1'b0;
    repeat (12) @(negedge clk);
    run_en = 1'b0;
    check("R7 one step per falling edge", cnt_o, 5);
    evt_i = 1'b1;
    repeat (4) @(negedge clk);

    // R5 PWM duty
    duty(8'd0,   0,   "R5 compare 0 duty");
    duty(8'd255, 255, "R5 compare 255 duty");
    duty(8'd64,  64,  "R5 compare 64 duty");
    // R4 upper byte reads zero in PWM mode
    setup(7'h02, 16'h0000, 16'h00FF);
    run_for(2);
    check("R4 upper byte zero", cnt_o, 16'h0001);
    // R5 low outside PWM mode
    setup(7'h01, 16'h00FF, 16'h0000);
    check("R5 low in reload mode", pwm_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule